// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM whose data bus can switch between reads and writes on consecutive clocks with no idle cycle. Address, control and byte enables are captured on the rising clock edge. Write data trails its command by the same number of cycles as read data, so the two directions line up on the bus. A small on-chip array holds the contents. The data bus is split into an input, an output and an output-enable.

A static mode input chooses one of two modes. In registered mode, read data leaves through an output register and write data is taken two enabled edges after the command. In flow-through mode, both pipelines are one edge shorter. A 2-bit burst generator lets a command reuse the previous operation type at the next address, in linear or interleaved order. Other inputs:
- three chip enables;
- an active-low clock enable that stalls the device;
- an asynchronous output-enable override;
- a sleep input with entry and wake-up delays.

In registered mode, a read that hits a write still waiting for its data returns the arriving bytes.

Top module: `zt_sram`

## Requirements
- R1: After reset `dq_oe_o` and `wake_err_o` are low. A command with `adv_i` low and not all of `cs1_ni`=0, `cs2_i`=1 and `cs3_ni`=0 is a deselect. A deselect neither drives the bus nor writes.
- R2: With `flow_i`=0, a read taken at enabled edge n drives `dq_o` with `dq_oe_o` high from enabled edge n+1 until edge n+2.
- R3: With `flow_i`=0, a write taken at enabled edge n stores `dq_i` as sampled at enabled edge n+2.
- R4: With `flow_i`=1, a read taken at edge n is driven right after edge n, and a write taken at edge n stores `dq_i` sampled at edge n+1.
- R5: Reads and writes can alternate on consecutive edges with every read returning the correct data.
- R6: `be_ni[k]`=0 enables writing lane k, bits 9k+8..9k. A write with all `be_ni` bits high changes nothing.
- R7: `adv_i`=1 repeats the previous operation (read, write or deselect) at the next burst address. With `ilv_i`=0 the low two address bits run start+1, start+2, start+3 (mod 4), then wrap back to start.
- R8: With `ilv_i`=1 the low two address bits of a burst are start XOR 1, 2, 3, then start again.
- R9: While `cke_ni`=1 all state holds. A driven read stays driven with the same data, and a pending write stays undriven and samples no data.
- R10: `oe_ni`=1 forces `dq_oe_o` low with no clock edge. The bus is never driven for a write.
- R11: Once `sleep_i`=1 is sampled at edge s, the bus is undriven from edge s+1. Commands from edge s+2 on are ignored, and the array is kept.
- R12: Once `sleep_i`=0 is sampled at edge e, commands at e and e+1 are still ignored. At e+2 and e+3, reads are accepted, and a write is dropped with `wake_err_o` high for the following cycle. From e+4 operation is normal.
- R13: With `flow_i`=0, a read at edge n to the address of a write taken at n-1 returns that write's enabled lanes from `dq_i` at edge n+1, and the array for the other lanes.
- R14: `adv_i`=1 after a deselect is a deselect continue and does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high stalls |
| cs1_ni | input | 1 | Chip enable, active low |
| cs2_i | input | 1 | Chip enable, active high |
| cs3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1: continue burst, 0: load new address |
| we_ni | input | 1 | Write enable, active low |
| be_ni | input | NB | Byte lane write enables, active low |
| addr_i | input | AW | Word address |
| dq_i | input | NB*9 | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| flow_i | input | 1 | 1: flow-through, 0: registered (static) |
| ilv_i | input | 1 | 1: interleaved burst, 0: linear (static) |
| dq_o | output | NB*9 | Read data |
| dq_oe_o | output | 1 | Read data drive enable |
| wake_err_o | output | 1 | Write rejected during wake-up window |

## Verification
The hardest situation to reach is the wake-up window. It needs a full sleep entry and exit, and the edges just after `sleep_i` falls must be counted exactly: two edges are ignored and two allow only reads. The stimulus holds sleep for several cycles and issues the same write on every edge from the release onward. It checks `wake_err_o` after each of those edges. It then reads the address back to show that neither the sleeping writes nor the rejected write touched the array. The forwarding case follows a similar pattern: a partial write immediately followed by a read of the same word, with the write data arriving on the edge that loads the read.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two bits of the i-th burst address
  function automatic logic [1:0] burst_lo(logic ilv, logic [1:0] start, logic [1:0] idx);
    return ilv ? (start ^ idx) : (start + idx);
  endfunction
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + 2'd1;
  assign addr_o  = load_i ? addr_i
                          : {base_q[AW-1:2], burst_lo(ilv_i, base_q[1:0], cnt_nxt)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  a_r9_burst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(base_q)));
  a_r7_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (cnt_q == $past(cnt_q) + 2'd1));
endmodule

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o,
  output logic waking_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [1:0]    z_q;
  logic [CW-1:0] wcnt_q;

  assign asleep_o = z_q[1];
  assign waking_o = !z_q[1] && (wcnt_q != '0);

  // free-running: sleep timing does not depend on the clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q    <= '0;
      wcnt_q <= '0;
    end else begin
      z_q <= {z_q[0], sleep_i};
      if (z_q[1])              wcnt_q <= CW'(WAKE_CYC);
      else if (wcnt_q != '0)   wcnt_q <= wcnt_q - CW'(1);
    end
  end

  a_r11_entry_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(sleep_i, 2));
  a_r12_window_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> waking_o);
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int NB       = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cke_ni,
  input  logic               cs1_ni,
  input  logic               cs2_i,
  input  logic               cs3_ni,
  input  logic               adv_i,
  input  logic               we_ni,
  input  logic [NB-1:0]      be_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [NB*LANE_W-1:0] dq_i,
  input  logic               oe_ni,
  input  logic               sleep_i,
  input  logic               flow_i,
  input  logic               ilv_i,
  output logic [NB*LANE_W-1:0] dq_o,
  output logic               dq_oe_o,
  output logic               wake_err_o
);
  localparam int DW    = NB * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic en, live, sel, asleep, waking, wr_blocked;
  op_e  op_raw, op, last_q;
  logic [AW-1:0] cur_addr;

  op_e           s1_op_q, s2_op_q;
  logic [AW-1:0] s1_addr_q, s2_addr_q;
  logic [NB-1:0] s1_be_q, s2_be_q;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word, merged, out_q;
  logic          out_vld_q, fwd_hit, rd_drive, wake_err_q;

  op_e           w_op;
  logic [AW-1:0] w_addr;
  logic [NB-1:0] w_be;

  assign en   = !cke_ni;
  assign live = en && !asleep;
  assign sel  = !cs1_ni && cs2_i && !cs3_ni;

  always_comb begin
    if (!adv_i) op_raw = sel ? (we_ni ? OP_RD : OP_WR) : OP_NONE;
    else        op_raw = last_q;
  end

  assign wr_blocked = waking && (op_raw == OP_WR);
  assign op         = wr_blocked ? OP_NONE : op_raw;

  zt_sleep_ctl #(.WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .asleep_o (asleep),
    .waking_o (waking)
  );

  zt_burst_gen #(.AW(AW)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (live && !wr_blocked),
    .load_i (!adv_i),
    .ilv_i  (ilv_i),
    .addr_i (addr_i),
    .addr_o (cur_addr)
  );

  // command pipeline: stage 1 holds the command of the last enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= OP_NONE;
      s1_op_q   <= OP_NONE;
      s2_op_q   <= OP_NONE;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
      s1_be_q   <= '0;
      s2_be_q   <= '0;
    end else if (en) begin
      if (live && !wr_blocked) last_q <= op_raw;
      s1_op_q   <= live ? op : OP_NONE;
      s1_addr_q <= cur_addr;
      s1_be_q   <= ~be_ni;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
    end
  end

  // late write: one edge after command in flow-through, two in registered mode
  assign w_op   = flow_i ? s1_op_q   : s2_op_q;
  assign w_addr = flow_i ? s1_addr_q : s2_addr_q;
  assign w_be   = flow_i ? s1_be_q   : s2_be_q;

  always_ff @(posedge clk_i) begin
    if (en && (w_op == OP_WR)) begin
      for (int l = 0; l < NB; l++) begin
        if (w_be[l]) mem[w_addr][l*LANE_W +: LANE_W] <= dq_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word = mem[s1_addr_q];
  assign fwd_hit = !flow_i && (s1_op_q == OP_RD) && (s2_op_q == OP_WR)
                   && (s2_addr_q == s1_addr_q);

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (fwd_hit && s2_be_q[l])
                                        ? dq_i[l*LANE_W +: LANE_W]
                                        : rd_word[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q  <= 1'b0;
      out_q      <= '0;
      wake_err_q <= 1'b0;
    end else begin
      wake_err_q <= live && wr_blocked;
      if (en) begin
        out_vld_q <= (s1_op_q == OP_RD);
        if (s1_op_q == OP_RD) out_q <= merged;
      end
    end
  end

  assign rd_drive   = flow_i ? (s1_op_q == OP_RD) : out_vld_q;
  assign dq_o       = flow_i ? rd_word : out_q;
  assign dq_oe_o    = rd_drive && !oe_ni && !asleep;
  assign wake_err_o = wake_err_q;

  a_r10_oe_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);
  a_r11_quiet_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |-> !dq_oe_o);
  a_r12_err_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_err_o |-> $past(waking && !cke_ni));
  a_r10_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_i && $past(en && (s1_op_q == OP_WR))) |-> !dq_oe_o);
  a_r14_desel_continue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && adv_i && (last_q == OP_NONE)) |=> (s1_op_q == OP_NONE));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_n, cs1_n, cs2, cs3_n, adv, we_n, oe_n, sleep, flow, ilv;
  logic [NB-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe, werr;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  zt_sram #(.AW(AW), .NB(NB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_ni(cke_n), .cs1_ni(cs1_n), .cs2_i(cs2),
    .cs3_ni(cs3_n), .adv_i(adv), .we_ni(we_n), .be_ni(be_n), .addr_i(addr),
    .dq_i(dq_in), .oe_ni(oe_n), .sleep_i(sleep), .flow_i(flow), .ilv_i(ilv),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .wake_err_o(werr)
  );

  localparam logic [DW-1:0] JUNK = 18'h2DEAD;

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 18'h0101 ^ 18'h2A5A);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic c_nop();
    cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0; adv = 1'b0; we_n = 1'b1; be_n = '1;
  endtask

  task automatic c_rd(int a);
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; adv = 1'b0; we_n = 1'b1; be_n = '1;
    addr = AW'(a);
  endtask

  task automatic c_wr(int a, logic [NB-1:0] ben);
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; adv = 1'b0; we_n = 1'b0; be_n = ben;
    addr = AW'(a);
  endtask

  task automatic c_cont(logic [NB-1:0] ben);
    adv = 1'b1; be_n = ben; addr = '0;
  endtask

  // registered-mode write: data two edges after the command
  task automatic pwrite(int a, logic [DW-1:0] d, logic [NB-1:0] ben);
    c_wr(a, ben); tick();
    c_nop(); tick();
    dq_in = d; tick();
    dq_in = JUNK;
  endtask

  task automatic pread_chk(string tag, int a, logic [DW-1:0] exp);
    c_rd(a); tick();
    c_nop(); tick();
    check({tag, " data"}, 32'(dq_out), 32'(exp));
    check({tag, " drive"}, 32'(dq_oe), 32'd1);
  endtask

  task automatic t_reset();
    check("R1 reset drive", 32'(dq_oe), 32'd0);
    check("R1 reset err", 32'(werr), 32'd0);
  endtask

  task automatic t_pipe();
    c_wr(5, 2'b00); tick();
    c_wr(6, 2'b00); tick();
    c_rd(5); dq_in = pat(5); tick();
    check("R2 no drive before read", 32'(dq_oe), 32'd0);
    c_rd(6); dq_in = pat(6); tick();
    check("R2 read latency data", 32'(dq_out), 32'(pat(5)));
    check("R2 read latency drive", 32'(dq_oe), 32'd1);
    c_nop(); dq_in = JUNK; tick();
    check("R3 late write data", 32'(dq_out), 32'(pat(6)));
    c_rd(5); tick();
    c_wr(7, 2'b00); tick();
    check("R5 read before write", 32'(dq_out), 32'(pat(5)));
    c_rd(6); tick();
    check("R10 write slot undriven", 32'(dq_oe), 32'd0);
    c_nop(); dq_in = pat(7); tick();
    check("R5 read after write", 32'(dq_out), 32'(pat(6)));
    dq_in = JUNK; tick();
    pread_chk("R5 interleaved write", 7, pat(7));
  endtask

  task automatic t_merge();
    pwrite(9, {9'h1AA, 9'h055}, 2'b00);
    c_wr(9, 2'b10); tick();
    c_rd(9); tick();
    c_nop(); dq_in = {9'h111, 9'h0EE}; tick();
    check("R13 forwarded lane", 32'(dq_out), 32'({9'h1AA, 9'h0EE}));
    dq_in = JUNK; tick();
    pread_chk("R13 array after forward", 9, {9'h1AA, 9'h0EE});
  endtask

  task automatic t_bytes();
    pwrite(12, {9'h0F0, 9'h10F}, 2'b00);
    pwrite(12, {9'h1C3, 9'h03C}, 2'b01);
    pread_chk("R6 upper lane only", 12, {9'h1C3, 9'h10F});
    pwrite(12, 18'h0, 2'b11);
    pread_chk("R6 write abort", 12, {9'h1C3, 9'h10F});
  endtask

  task automatic t_flow();
    flow = 1'b1;
    c_wr(20, 2'b00); tick();
    check("R4 write undriven", 32'(dq_oe), 32'd0);
    c_rd(20); dq_in = pat(20); tick();
    check("R4 flow read data", 32'(dq_out), 32'(pat(20)));
    check("R4 flow read drive", 32'(dq_oe), 32'd1);
    c_wr(21, 2'b00); dq_in = JUNK; tick();
    check("R4 turn to write", 32'(dq_oe), 32'd0);
    c_rd(21); dq_in = pat(21); tick();
    check("R4 flow second read", 32'(dq_out), 32'(pat(21)));
    c_nop(); dq_in = JUNK; tick();
    tick();
    flow = 1'b0;
    tick();
  endtask

  task automatic t_burst_lin();
    ilv = 1'b0;
    c_wr(32, 2'b00); tick();
    c_cont(2'b00); tick();
    c_cont(2'b00); dq_in = pat(32); tick();
    c_cont(2'b00); dq_in = pat(33); tick();
    c_nop(); dq_in = pat(34); tick();
    dq_in = pat(35); tick();
    dq_in = JUNK;
    begin
      int seq [5] = '{34, 35, 32, 33, 34};
      c_rd(34); tick();
      for (int i = 0; i < 4; i++) begin
        c_cont(2'b11); tick();
        check($sformatf("R7 linear step %0d", i), 32'(dq_out), 32'(pat(seq[i])));
      end
      c_nop(); tick();
      check("R7 linear wrap", 32'(dq_out), 32'(pat(seq[4])));
    end
  endtask

  task automatic t_burst_ilv();
    int seq [5] = '{33, 32, 35, 34, 33};
    ilv = 1'b1;
    c_rd(33); tick();
    for (int i = 0; i < 4; i++) begin
      c_cont(2'b11); tick();
      check($sformatf("R8 interleaved step %0d", i), 32'(dq_out), 32'(pat(seq[i])));
    end
    c_nop(); tick();
    check("R8 interleaved wrap", 32'(dq_out), 32'(pat(seq[4])));
    ilv = 1'b0;
  endtask

  task automatic t_stall();
    c_rd(34); tick();
    c_rd(35); tick();
    check("R9 before stall", 32'(dq_out), 32'(pat(34)));
    cke_n = 1'b1; c_nop(); tick();
    check("R9 stall data held", 32'(dq_out), 32'(pat(34)));
    tick();
    check("R9 stall still driven", 32'(dq_oe), 32'd1);
    cke_n = 1'b0; tick();
    check("R9 resume", 32'(dq_out), 32'(pat(35)));
    c_wr(36, 2'b00); tick();
    c_nop(); cke_n = 1'b1; tick();
    check("R9 write stall undriven", 32'(dq_oe), 32'd0);
    tick();
    cke_n = 1'b0; tick();
    dq_in = pat(36); tick();
    dq_in = JUNK;
    pread_chk("R9 write across stall", 36, pat(36));
  endtask

  task automatic t_oe();
    c_rd(35); tick();
    c_nop(); tick();
    oe_n = 1'b1; #1;
    check("R10 async disable", 32'(dq_oe), 32'd0);
    oe_n = 1'b0; #1;
    check("R10 async enable", 32'(dq_oe), 32'd1);
    tick();
  endtask

  task automatic t_desel();
    pwrite(50, pat(50), 2'b00);
    c_wr(50, 2'b00); cs1_n = 1'b1; tick();
    c_nop(); tick();
    dq_in = pat(7); tick();
    dq_in = JUNK;
    pread_chk("R1 deselected write", 50, pat(50));
    c_rd(50); cs2 = 1'b0; tick();
    c_cont(2'b11); tick();
    check("R1 deselected read", 32'(dq_oe), 32'd0);
    c_nop(); tick();
    check("R14 deselect continue", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_sleep();
    pwrite(60, pat(60), 2'b00);
    c_rd(60); sleep = 1'b1; tick();
    c_nop(); tick();
    check("R11 undriven asleep", 32'(dq_oe), 32'd0);
    c_wr(60, 2'b00);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R11 still undriven", 32'(dq_oe), 32'd0);
    end
    sleep = 1'b0; tick();
    check("R12 edge e ignored", 32'(werr), 32'd0);
    tick();
    check("R12 edge e+1 ignored", 32'(werr), 32'd0);
    tick();
    check("R12 write rejected", 32'(werr), 32'd1);
    c_rd(60); tick();
    check("R12 error one cycle", 32'(werr), 32'd0);
    c_nop(); tick();
    check("R12 read in window", 32'(dq_out), 32'(pat(60)));
    check("R11 contents kept", 32'(dq_oe), 32'd1);
    c_wr(61, 2'b00); tick();
    check("R12 normal write", 32'(werr), 32'd0);
    c_nop(); tick();
    dq_in = pat(61); tick();
    dq_in = JUNK;
    pread_chk("R12 write after window", 61, pat(61));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cke_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; flow = 1'b0; ilv = 1'b0;
    dq_in = JUNK; addr = '0;
    c_nop();
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_pipe();
    t_merge();
    t_bytes();
    t_flow();
    t_burst_lin();
    t_burst_ilv();
    t_stall();
    t_oe();
    t_desel();
    t_sleep();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule